// File: doc/BRIEF.md
# Two-Level Thermal Shutdown Controller

This block protects four line drivers against overheating. Two temperature comparators feed it, one for a warning level and one for a critical level. Each line also has a current-overload flag. At the warning level the block turns off only the lines that are overloaded. At the critical level it turns off every line and raises a global shutdown flag.

Each trip is kept in a sticky per-line trip register. A host interface supplies the requested line enables and a per-line clear request. A tripped line stays off until the host does two things: it withdraws that line's enable, and it clears the trip bit. The trip bit can only be cleared once the critical-temperature condition has gone away.

All comparator and overload inputs are asynchronous. They pass through a two-flop synchroniser. Host-side inputs are already synchronous to the clock.

Top module: `thermal_guard`

## Requirements
- R1: While rst_ni is low, en_o, trip_o and shut_o are all 0, whatever req_en_i is.
- R2: With temp_lo_i high and temp_hi_i low, each line whose ovl_i bit is high gets trip_o bit set and en_o bit cleared. Lines whose ovl_i bit is low are left unchanged.
- R3: With temp_hi_i high, all four trip_o bits are set and shut_o is 1, so every en_o bit is 0.
- R4: shut_o goes to 0 only because temp_hi_i went low. A host clear request never clears it.
- R5: A trip_o bit stays set after the temperature and overload inputs that set it have gone away.
- R6: A clear_i bit n, sampled at a clock edge while req_en_i bit n is 0 and shut_o is 0, clears trip_o bit n at that edge.
- R7: A clear_i bit n is ignored while req_en_i bit n is 1.
- R8: A clear_i request is ignored while shut_o is 1.
- R9: en_o bit n equals req_en_i bit n AND NOT trip_o bit n AND NOT shut_o.
- R10: A change on ovl_i, temp_lo_i or temp_hi_i applied just after clock edge k shows on trip_o and shut_o just after edge k+3, and not before.
- R11: An ovl_i bit has no effect while both temperature inputs are low.
- R12: If a trip condition and a valid clear for the same line coincide, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_en_i | input | 4 | Line enables requested by the host |
| ovl_i | input | 4 | Per-line current-overload flags (asynchronous) |
| temp_lo_i | input | 1 | Warning-level temperature comparator (asynchronous) |
| temp_hi_i | input | 1 | Critical-level temperature comparator (asynchronous) |
| clear_i | input | 4 | Per-line trip clear request from the host |
| en_o | output | 4 | Gated driver enables |
| trip_o | output | 4 | Sticky per-line thermal trip register |
| shut_o | output | 1 | Global shutdown flag, set by critical temperature |

## Verification
The main sweep covers all four states of the two temperature inputs. For each state it tries all sixteen overload patterns against all sixteen requested-enable patterns. This separates selective tripping from global tripping. It also shows that overload alone does nothing, and that the gating depends on each bit of the request.

Directed sequences then check the following:
- the edge on which a trip appears;
- that trips persist once their cause is removed;
- that clears are refused while a line is still enabled, and while the shutdown flag is set;
- that a trip condition beats a clear that arrives in the same cycle.

// File: rtl/thermal_guard_pkg.sv
package thermal_guard_pkg;
  localparam int unsigned TG_LINES_DEF = 4;
  localparam int unsigned TG_SYNC_DEF  = 2;

  typedef enum logic [1:0] {
    TEMP_NORMAL = 2'b00,
    TEMP_WARN   = 2'b01,
    TEMP_CRIT   = 2'b10
  } temp_level_e;

  function automatic temp_level_e classify_temp(input logic lo, input logic hi);
    if (hi)      return TEMP_CRIT;
    else if (lo) return TEMP_WARN;
    else         return TEMP_NORMAL;
  endfunction
endpackage

// File: rtl/tg_sync.sv
module tg_sync #(
  parameter int unsigned WIDTH  = 6,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] st_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(STAGES); i++) st_q[i] <= '0;
    end else begin
      st_q[0] <= d_i;
      for (int i = 1; i < int'(STAGES); i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/tg_trip_reg.sv
module tg_trip_reg
  import thermal_guard_pkg::*;
#(
  parameter int unsigned LINES = TG_LINES_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] ovl_s_i,
  input  logic             lo_s_i,
  input  logic             hi_s_i,
  input  logic [LINES-1:0] req_en_i,
  input  logic [LINES-1:0] clear_i,
  output logic [LINES-1:0] trip_o,
  output logic             shut_o
);
  logic [LINES-1:0] trip_q, trip_d, set_mask, clr_mask;
  logic             shut_q;
  temp_level_e      level;

  assign level = classify_temp(lo_s_i, hi_s_i);

  always_comb begin
    unique case (level)
      TEMP_CRIT: set_mask = '1;
      TEMP_WARN: set_mask = ovl_s_i;
      default:   set_mask = '0;
    endcase
  end

  // clear only for disabled lines and outside global shutdown
  assign clr_mask = clear_i & ~req_en_i & {LINES{~shut_q}};

  // set wins over clear
  assign trip_d = (trip_q & ~clr_mask) | set_mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trip_q <= '0;
      shut_q <= 1'b0;
    end else begin
      trip_q <= trip_d;
      shut_q <= hi_s_i;
    end
  end

  assign trip_o = trip_q;
  assign shut_o = shut_q;

  assert_hi_trips_all_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_s_i |=> (&trip_q && shut_q));

  assert_shut_release_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(shut_q) |-> !$past(hi_s_i));

  assert_lo_selective_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_s_i && !hi_s_i) |=> ((trip_q & $past(ovl_s_i)) == $past(ovl_s_i)));

  for (genvar n = 0; n < LINES; n++) begin : g_chk
    assert_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(trip_q[n]) |-> $past(clear_i[n] && !req_en_i[n] && !shut_q));

    assert_set_wins_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_mask[n] && clear_i[n]) |=> trip_q[n]);
  end
endmodule

// File: rtl/tg_gate.sv
module tg_gate #(
  parameter int unsigned LINES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] req_en_i,
  input  logic [LINES-1:0] trip_i,
  input  logic             shut_i,
  output logic [LINES-1:0] en_o
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  for (genvar n = 0; n < LINES; n++) begin : g_line
    assign en_o[n] = armed_q & req_en_i[n] & ~trip_i[n] & ~shut_i;
  end

  always_comb begin
    if (rst_ni) assert_off_in_shutdown_R3: assert (!(shut_i && (en_o != '0)));
  end
endmodule

// File: rtl/thermal_guard.sv
module thermal_guard
  import thermal_guard_pkg::*;
#(
  parameter int unsigned LINES       = TG_LINES_DEF,
  parameter int unsigned SYNC_STAGES = TG_SYNC_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] req_en_i,
  input  logic [LINES-1:0] ovl_i,
  input  logic             temp_lo_i,
  input  logic             temp_hi_i,
  input  logic [LINES-1:0] clear_i,
  output logic [LINES-1:0] en_o,
  output logic [LINES-1:0] trip_o,
  output logic             shut_o
);
  localparam int unsigned SW = LINES + 2;

  logic [SW-1:0]    raw, syn;
  logic [LINES-1:0] ovl_s;
  logic             lo_s, hi_s;

  assign raw = {temp_hi_i, temp_lo_i, ovl_i};
  assign {hi_s, lo_s, ovl_s} = syn;

  tg_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(raw), .q_o(syn)
  );

  tg_trip_reg #(.LINES(LINES)) u_trip (
    .clk_i, .rst_ni,
    .ovl_s_i(ovl_s), .lo_s_i(lo_s), .hi_s_i(hi_s),
    .req_en_i, .clear_i,
    .trip_o, .shut_o
  );

  tg_gate #(.LINES(LINES)) u_gate (
    .clk_i, .rst_ni,
    .req_en_i, .trip_i(trip_o), .shut_i(shut_o),
    .en_o
  );

  always_comb begin
    if (!rst_ni) assert_reset_off_R1: assert (en_o == '0);
  end

  assert_tripped_line_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((en_o & trip_o) == '0));
endmodule

// File: tb/tb_thermal_guard.sv
module tb_thermal_guard;
  localparam int N = 4;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] req_en = '0, ovl = '0, clr = '0;
  logic lo = 1'b0, hi = 1'b0;
  logic [N-1:0] en, trip;
  logic shut;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  thermal_guard dut (
    .clk_i(clk), .rst_ni(rst_n), .req_en_i(req_en), .ovl_i(ovl),
    .temp_lo_i(lo), .temp_hi_i(hi), .clear_i(clr),
    .en_o(en), .trip_o(trip), .shut_o(shut)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic scrub();
    req_en = '0; ovl = '0; lo = 0; hi = 0; clr = '0;
    step(4);
    clr = '1; step(1); clr = '0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] exp_trip;
    req_en = '1;
    #7;
    check("R1 en", en, 0);
    check("R1 trip", trip, 0);
    check("R1 shut", shut, 0);
    rst_n = 1'b1;
    step(2);

    // sweep
    for (int t = 0; t < 4; t++) begin
      for (int o = 0; o < 16; o++) begin
        for (int r = 0; r < 16; r++) begin
          scrub();
          check("R6 scrub", trip, 0);
          req_en = r[N-1:0]; ovl = o[N-1:0]; lo = t[0]; hi = t[1];
          step(4);
          exp_trip = t[1] ? 4'hF : (t[0] ? o[N-1:0] : 4'h0);
          if (t == 0)      check("R11 trip", trip, exp_trip);
          else if (t == 1) check("R2 trip", trip, exp_trip);
          else             check("R3 trip", trip, exp_trip);
          check("R3 shut", shut, t[1]);
          check("R9 en", en, r[N-1:0] & ~exp_trip & {N{~t[1]}});
        end
      end
    end

    // latency
    scrub();
    req_en = '1; ovl = 4'b0101; lo = 1;
    step(2);
    check("R10 early", trip, 0);
    step(1);
    check("R10 on time", trip, 4'b0101);
    check("R2 en", en, 4'b1010);

    // sticky
    lo = 0; ovl = '0;
    step(5);
    check("R5 sticky", trip, 4'b0101);

    // clear while enabled
    clr = 4'b0101; step(1); clr = '0;
    check("R7 ignored", trip, 4'b0101);

    // clear after disabling line 0 only
    req_en = 4'b1110;
    clr = 4'b0101; step(1); clr = '0;
    check("R6 clear", trip, 4'b0100);
    check("R9 en", en, 4'b1010);

    // critical shutdown
    scrub();
    req_en = '1; hi = 1;
    step(2);
    check("R10 shut early", shut, 0);
    step(1);
    check("R3 shut on", shut, 1);
    check("R3 en off", en, 0);
    req_en = '0; clr = '1; step(1); clr = '0;
    check("R8 ignored", trip, 4'hF);
    check("R4 host", shut, 1);
    hi = 0;
    step(2);
    check("R4 held", shut, 1);
    step(1);
    check("R4 release", shut, 0);
    check("R5 after hi", trip, 4'hF);
    clr = '1; step(1); clr = '0;
    check("R6 after hi", trip, 0);

    // set beats clear
    scrub();
    lo = 1; ovl = 4'b0011;
    step(4);
    clr = 4'b0011; step(1); clr = '0;
    check("R12 set wins", trip, 4'b0011);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule